// File: doc/BRIEF.md
# Message Object Staging and Transfer Engine

This block sits between a host register port and a store of 32 message objects used by a CAN-style controller. It holds two identical staging channels. Each channel has a buffer for one message object, split into five words: mask, arbitration, control, data A and data B. Each channel also has a command word and a request word. The host first fills the buffer and the command word. It then writes an object number to the request word. The channel copies the selected words between its buffer and the chosen object in the shared store. The command word picks the direction and the words to move.

Both channels can have a transfer pending at the same time, so one channel can fill the store while the other empties it. A fixed-priority arbiter gives the single-port store to at most one channel per cycle. Each channel shows a busy flag for the length of its transfer. While the flag is set, the channel refuses host writes to its own registers.

Top module: `msgbuf_xfer`

## Requirements
- R1: After synchronous reset, every buffer word, command word and stored object number reads zero, busy is low, and every word of every object in the store is zero.
- R2: The host register select `host_sel` uses these codes. Codes 0 to 4 are buffer words: mask, arbitration, control, data A, data B. Code 5 is the command word, of which bits [5:0] are kept. Code 6 is the request word: a read returns the object number in bits [5:0] and busy in bit 15. Code 7 reads zero. Written buffer and command values read back unchanged on `host_rdata`.
- R3: A request write with a value from 1 to 32, made while the channel is idle, starts a transfer on that object, and busy is high in the cycle after the write. A request value of 0, or any value above 32, is ignored: busy stays low and the store is not changed.
- R4: Command bit 5 sets the direction: 1 copies the buffer into the store, 0 copies the store into the buffer.
- R5: Command bits 0 to 4 select mask, arbitration, control, data A and data B in that order. Words that are not selected are left unchanged at the destination.
- R6: The store is accessed once per selected word, lowest word first. With no contention, busy stays high for as many cycles as there are selected words, or for one cycle if none is selected.
- R7: While a channel is busy, host writes to any of that channel's registers are ignored, including a second request.
- R8: When both channels need the store in the same cycle, channel 0 is served and channel 1 waits. A transfer by channel 0 that ends before channel 1's word is served is visible to channel 1's read.
- R9: Objects 1 and 32 are reached, each object number selects its own storage, and a full object written by one channel reads back intact through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_chan | input | 1 | Channel addressed by the write |
| host_sel | input | 3 | Register addressed by the write |
| host_wdata | input | 32 | Write data |
| host_rchan | input | 1 | Channel addressed by the read |
| host_rsel | input | 3 | Register addressed by the read |
| host_rdata | output | 32 | Read data (combinational) |
| busy | output | 2 | Per-channel transfer in progress |

## Verification
The bench aims at these cases:
- **Object numbers at the limits.** Requests of 0 and 33 must be ignored, and objects 1 and 32 must be reached. A decoder that is off by one would either start a transfer on 0 or 33 or miss one of the end objects.
- **Partial field selections.** Only the selected words may change at the destination. A design that copied the whole object would overwrite the unselected words, and the reference model shows this at once.
- **Busy length for an empty selection.** A selection of no words must hold busy for exactly one cycle. A design that got this wrong would hang or drop the flag too early.
- **Contention and host writes while busy.** Channel 1 requests while channel 0 is still moving a full object. Reversed priority would change busy timing and the data channel 1 reads. A locking fault would let a write made during busy show up in the buffer.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int FLD_W      = 3;
    localparam int CMD_W      = 6;

    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_ARB    = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_DATA_A = 3'd3,
        SEL_DATA_B = 3'd4,
        SEL_CMD    = 3'd5,
        SEL_REQ    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic                  to_store;
        logic [NUM_FIELDS-1:0] fields;
    } cmd_t;

    function automatic logic [FLD_W-1:0] first_field(input logic [NUM_FIELDS-1:0] v);
        logic [FLD_W-1:0] idx;
        idx = '0;
        for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
            if (v[i]) idx = FLD_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/msgbuf_store.sv
module msgbuf_store
    import msgbuf_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(N_OBJ),
    localparam int AW    = IDX_W + FLD_W,
    localparam int DEPTH = N_OBJ * (1 << FLD_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/msgbuf_arb.sv
module msgbuf_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst) (grant & ~req) == '0);

    generate
        for (genvar g = 1; g < N; g++) begin : g_prio
            // R8
            lower_first_chk: assert property (@(posedge clk) disable iff (rst)
                grant[g] |-> !(|req[g-1:0]));
        end
    endgenerate

endmodule

// File: rtl/msgbuf_chan.sv
module msgbuf_chan
    import msgbuf_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(N_OBJ),
    localparam int OBJ_W = $clog2(N_OBJ + 1),
    localparam int AW    = IDX_W + FLD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          ram_req,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    input  logic          grant,
    output logic          busy
);

    logic [NUM_FIELDS-1:0][DW-1:0] bufs;
    cmd_t                          cmd_r;
    logic [OBJ_W-1:0]              obj_r;
    logic                          busy_r;
    logic [NUM_FIELDS-1:0]         pend_r;

    logic [FLD_W-1:0]      fld;
    logic [NUM_FIELDS-1:0] fld_bit;
    logic [IDX_W-1:0]      obj_idx;
    logic                  obj_ok;
    logic                  start;

    assign obj_ok  = (wr_data >= DW'(1)) && (wr_data <= DW'(N_OBJ));
    assign start   = wr_en && !busy_r && (reg_sel_e'(wr_sel) == SEL_REQ) && obj_ok;
    assign fld     = first_field(pend_r);
    assign fld_bit = NUM_FIELDS'(1) << fld;
    assign obj_idx = IDX_W'(obj_r - OBJ_W'(1));

    assign ram_req   = busy_r && (|pend_r);
    assign ram_we    = cmd_r.to_store;
    assign ram_addr  = {obj_idx, fld};
    assign ram_wdata = bufs[fld];
    assign busy      = busy_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            bufs   <= '0;
            cmd_r  <= '0;
            obj_r  <= '0;
            busy_r <= 1'b0;
            pend_r <= '0;
        end else if (!busy_r) begin
            if (wr_en) begin
                case (reg_sel_e'(wr_sel))
                    SEL_MASK, SEL_ARB, SEL_CTRL, SEL_DATA_A, SEL_DATA_B:
                        bufs[wr_sel] <= wr_data;
                    SEL_CMD:
                        cmd_r <= cmd_t'(wr_data[CMD_W-1:0]);
                    SEL_REQ:
                        if (start) begin
                            obj_r  <= wr_data[OBJ_W-1:0];
                            busy_r <= 1'b1;
                            pend_r <= cmd_r.fields;
                        end
                    default: ;
                endcase
            end
        end else if (grant) begin
            pend_r <= pend_r & ~fld_bit;
            if (!cmd_r.to_store) bufs[fld] <= ram_rdata;
            if ((pend_r & ~fld_bit) == '0) busy_r <= 1'b0;
        end else if (pend_r == '0) begin
            busy_r <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_MASK, SEL_ARB, SEL_CTRL, SEL_DATA_A, SEL_DATA_B:
                rd_data = bufs[rd_sel];
            SEL_CMD:
                rd_data[CMD_W-1:0] = cmd_r;
            SEL_REQ: begin
                rd_data[OBJ_W-1:0] = obj_r;
                rd_data[15]        = busy_r;
            end
            default: rd_data = '0;
        endcase
    end

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && reg_sel_e'(wr_sel) == SEL_REQ && obj_ok) |=> busy);

    // R3
    bad_obj_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && reg_sel_e'(wr_sel) == SEL_REQ && !obj_ok) |=> !busy);

    // R7
    locked_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_r.to_store) |=> $stable(bufs));

    // R6
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ram_req) |=> !busy);

endmodule

// File: rtl/msgbuf_xfer.sv
module msgbuf_xfer
    import msgbuf_pkg::*;
#(
    parameter int N_CHAN = 2,
    parameter int N_OBJ  = 32,
    parameter int DW     = 32,
    localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
    localparam int IDX_W = $clog2(N_OBJ),
    localparam int AW    = IDX_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [CH_W-1:0]   host_chan,
    input  logic [2:0]        host_sel,
    input  logic [DW-1:0]     host_wdata,
    input  logic [CH_W-1:0]   host_rchan,
    input  logic [2:0]        host_rsel,
    output logic [DW-1:0]     host_rdata,
    output logic [N_CHAN-1:0] busy
);

    logic [DW-1:0]     ch_rdata [N_CHAN];
    logic [AW-1:0]     ch_addr  [N_CHAN];
    logic [DW-1:0]     ch_wdata [N_CHAN];
    logic [N_CHAN-1:0] ch_req;
    logic [N_CHAN-1:0] ch_we;
    logic [N_CHAN-1:0] grant;

    logic          st_we;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_wdata;
    logic [DW-1:0] st_rdata;

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            msgbuf_chan #(.N_OBJ(N_OBJ), .DW(DW)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (host_we && (host_chan == CH_W'(c))),
                .wr_sel    (host_sel),
                .wr_data   (host_wdata),
                .rd_sel    (host_rsel),
                .rd_data   (ch_rdata[c]),
                .ram_req   (ch_req[c]),
                .ram_we    (ch_we[c]),
                .ram_addr  (ch_addr[c]),
                .ram_wdata (ch_wdata[c]),
                .ram_rdata (st_rdata),
                .grant     (grant[c]),
                .busy      (busy[c])
            );
        end
    endgenerate

    msgbuf_arb #(.N(N_CHAN)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (ch_req),
        .grant (grant)
    );

    always_comb begin
        st_we      = 1'b0;
        st_addr    = '0;
        st_wdata   = '0;
        host_rdata = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (grant[c]) begin
                st_we    = ch_we[c];
                st_addr  = ch_addr[c];
                st_wdata = ch_wdata[c];
            end
            if (host_rchan == CH_W'(c)) host_rdata = ch_rdata[c];
        end
    end

    msgbuf_store #(.N_OBJ(N_OBJ), .DW(DW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (st_we),
        .addr  (st_addr),
        .wdata (st_wdata),
        .rdata (st_rdata)
    );

endmodule

// File: tb/sim_msgbuf_xfer.sv
module sim_msgbuf_xfer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [0:0]  host_chan = '0;
    logic [2:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic [0:0]  host_rchan = '0;
    logic [2:0]  host_rsel = '0;
    logic [31:0] host_rdata;
    logic [1:0]  busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] mbuf [2][5];
    logic [5:0]  mcmd [2];
    logic [5:0]  mobj [2];
    logic        mbusy [2];
    logic [4:0]  mpend [2];
    logic [31:0] mram [32][5];

    always #(CLK_PERIOD / 2) clk = ~clk;

    msgbuf_xfer u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_chan(host_chan),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rchan(host_rchan),
        .host_rsel(host_rsel), .host_rdata(host_rdata), .busy(busy)
    );

    function automatic logic [31:0] exp_rd(int ch, int s);
        logic [31:0] r;
        r = '0;
        if (s < 5) r = mbuf[ch][s];
        else if (s == 5) r[5:0] = mcmd[ch];
        else if (s == 6) begin
            r[5:0] = mobj[ch];
            r[15]  = mbusy[ch];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                for (int f = 0; f < 5; f++) mbuf[c][f] = '0;
                mcmd[c] = '0; mobj[c] = '0; mbusy[c] = 1'b0; mpend[c] = '0;
            end
            for (int o = 0; o < 32; o++)
                for (int f = 0; f < 5; f++) mram[o][f] = '0;
        end else begin
            int g;
            g = -1;
            for (int c = 0; c < 2; c++)
                if (mbusy[c] && mpend[c] != 0 && g < 0) g = c;
            for (int c = 0; c < 2; c++) begin
                if (mbusy[c]) begin
                    if (c == g) begin
                        int f;
                        f = 0;
                        while (!mpend[c][f]) f++;
                        if (mcmd[c][5]) mram[mobj[c] - 1][f] = mbuf[c][f];
                        else mbuf[c][f] = mram[mobj[c] - 1][f];
                        mpend[c][f] = 1'b0;
                        if (mpend[c] == 0) mbusy[c] = 1'b0;
                    end else if (mpend[c] == 0) begin
                        mbusy[c] = 1'b0;
                    end
                end else if (host_we && int'(host_chan) == c) begin
                    if (host_sel < 5) mbuf[c][host_sel] = host_wdata;
                    else if (host_sel == 5) mcmd[c] = host_wdata[5:0];
                    else if (host_sel == 6 && host_wdata >= 1 && host_wdata <= 32) begin
                        mobj[c]  = host_wdata[5:0];
                        mbusy[c] = 1'b1;
                        mpend[c] = mcmd[c][4:0];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            logic [1:0]  eb;
            logic [31:0] er;
            eb = {mbusy[1], mbusy[0]};
            er = exp_rd(int'(host_rchan), int'(host_rsel));
            n_cmp++;
            if (busy !== eb) begin
                n_bad++;
                $display("FAIL %s busy actual=%b expected=%b t=%0t", cur_req, busy, eb, $time);
            end
            n_cmp++;
            if (host_rdata !== er) begin
                n_bad++;
                $display("FAIL %s rdata ch%0d sel%0d actual=%h expected=%h t=%0t",
                         cur_req, host_rchan, host_rsel, host_rdata, er, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(int ch, int s, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_chan = ch[0:0]; host_sel = s[2:0]; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rdall(int ch);
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            host_rchan = ch[0:0]; host_rsel = s[2:0];
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fill(int ch, logic [31:0] base);
        for (int f = 0; f < 5; f++) wr(ch, f, base + 32'(f));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of both channels
        cur_req = "R1";
        rdall(0); rdall(1);
        // R1: store is zero after reset, read object 20 in full
        wr(1, 3, 32'h1111_2222);
        wr(1, 5, 32'h1F);
        wr(1, 6, 20);
        idle(7); rdall(1);

        // R2: register map readback
        cur_req = "R2";
        fill(0, 32'hA000_0010);
        wr(0, 5, 32'hFFFF_FF3F);
        rdall(0);

        // R4, R7: full write to object 5, host writes during busy are ignored
        cur_req = "R7";
        wr(0, 6, 5);
        wr(0, 1, 32'hDEAD_BEEF);
        wr(0, 6, 9);
        idle(6); rdall(0);

        // R5: partial read of arbitration and data A into channel 1
        cur_req = "R5";
        fill(1, 32'h5500_0000);
        wr(1, 5, 32'h0A);
        wr(1, 6, 5);
        idle(4); rdall(1);

        // R3: invalid object numbers start nothing
        cur_req = "R3";
        wr(1, 6, 0);
        idle(2);
        wr(1, 6, 33);
        idle(2);
        wr(1, 6, 32'h8000_0003);
        idle(2); rdall(1);

        // R6: empty selection holds busy one cycle; data-only write
        cur_req = "R6";
        wr(0, 5, 32'h20);
        wr(0, 6, 7);
        idle(3);
        wr(0, 5, 32'h38);
        wr(0, 6, 7);
        idle(5);

        // R8: channel 1 requests while channel 0 moves a full object
        cur_req = "R8";
        fill(0, 32'hC0C0_0100);
        wr(0, 5, 32'h3F);
        wr(1, 5, 32'h1F);
        wr(0, 6, 12);
        wr(1, 6, 12);
        idle(12); rdall(1);

        // R9: end objects, cross-channel round trip
        cur_req = "R9";
        fill(1, 32'h7700_0200);
        wr(1, 5, 32'h3F);
        wr(1, 6, 32);
        idle(7);
        fill(0, 32'h3300_0300);
        wr(0, 6, 1);
        idle(7);
        wr(0, 5, 32'h1F);
        wr(0, 6, 32);
        idle(7); rdall(0);
        wr(1, 6, 1);
        idle(7); rdall(1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule